// File: doc/BRIEF.md
# Lane-Serial Packed Montgomery Multiplier (No Final Subtraction)

This block multiplies two 256-bit packed vectors lane by lane in Montgomery form. Both operands are treated as arrays of equal-width unsigned lanes. Each lane pair is reduced against a modulus `q` using a precomputed constant `mu`, where `mu` is the negated inverse of `q` modulo 2^d and d is the lane width. The unit skips the final compare-and-subtract, so a lane result may lie anywhere in [0, 2q) and is kept to d bits.

A single multiplier of the widest lane width serves all lanes. Each lane uses it three times: once for the full product c = a*b, once for t = low_d(low_d(c) * mu), and once for the reduction r = low_d((c + t*q) >> d). Software chooses the lane width per operation with a two-bit code. It pulses `startIn` while the unit is idle, then waits for the one-cycle `doneOut` pulse and reads the packed result.

Top module: `mmsimd_montmul`

## Requirements
- R1: `startIn` is acted on only while `busyOut` is low. `busyOut` is high from the cycle after an accepted start until the cycle after `doneOut`. A start while busy has no effect on the running operation or its result.
- R2: `doneOut` is high for exactly one cycle per accepted start. `resultOut` and `errOut` stay unchanged from that cycle until the next accepted start.
- R3: Element-length code 0 selects 32-bit lanes (8 lanes), code 1 selects 64-bit lanes (4 lanes) and code 2 selects 128-bit lanes (2 lanes). Only the low d bits of `modQIn` and `muIn` are used.
- R4: For each lane with operands a and b, the lane result is low_d((c + low_d(low_d(c)*mu)*q) >> d), where c = a*b is the full 2d-bit product.
- R5: No conditional subtraction of q takes place. A lane result equal to or above q is delivered as computed. For example, with q = 1, mu = 2^32-1 and 32-bit lanes a = b = 0x10000, every lane is 1.
- R6: Lane i of the result occupies bits [i*d + d-1 : i*d], with lane 0 in bits [d-1:0]. Lane i uses operand bits at the same positions.
- R7: Element-length code 3 is illegal. `doneOut` is then high in the cycle right after the start is sampled, with `errOut` = 1 and `resultOut` = 0. `errOut` is 0 after every legal operation.
- R8: For a legal code with N lanes, `doneOut` is high 3*N cycles after the first cycle that follows the clock edge that samples the start.
- R9: After reset, `busyOut`, `doneOut` and `errOut` are 0 and `resultOut` is 0.
- R10: The unit captures its operand, modulus, constant and code inputs when a start is accepted. Changing those inputs while busy does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start request, sampled while idle |
| elenIn | input | 2 | Lane-width code (0: 32, 1: 64, 2: 128, 3: illegal) |
| vecAIn | input | 256 | Packed operand A |
| vecBIn | input | 256 | Packed operand B |
| modQIn | input | 128 | Modulus q, low d bits used |
| muIn | input | 128 | Constant -q^-1 mod 2^d, low d bits used |
| busyOut | output | 1 | Operation in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| errOut | output | 1 | Last operation had an illegal code |
| resultOut | output | 256 | Packed lane results |

## Verification
A stale lane index or a wrong lane width shows up as a result word with lanes in the wrong place or left at zero. It also moves the `doneOut` pulse, because the lane count sets the latency; both appear at the first completion. A corrupted intermediate product or reduction value changes only the lane being processed, so each lane of a random vector is compared against an independent software model. A state machine that fails to return to idle shows up at once as a missing, repeated or mistimed done pulse. The scoreboard checks the pulse's exact cycle against 3*N.

// File: rtl/mmsimd_pkg.sv
package mmsimd_pkg;

  typedef struct packed {
    logic load;   // capture inputs, clear result
    logic mulAB;  // c = a * b
    logic mulMu;  // t = low(low(c) * mu)
    logic mulQ;   // lane = low((c + t*q) >> d)
  } mmStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AB,
    ST_MU,
    ST_Q,
    ST_DONE
  } mmState_t;

  localparam logic [1:0] ELEN_BAD = 2'd3;

endpackage

// File: rtl/mmsimd_ctrl.sv
module mmsimd_ctrl
  import mmsimd_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int BASE_W = 32,
  localparam int MAX_LANES = VEC_W / BASE_W,
  localparam int LIDX_W = $clog2(MAX_LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        elen,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        elenQ,
  output logic [LIDX_W-1:0] laneIdx,
  output mmStrobe_t         strobe
);

  mmState_t state;
  logic [LIDX_W-1:0] lastIdx;

  assign lastIdx = LIDX_W'((MAX_LANES >> elenQ) - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      laneIdx <= '0;
      elenQ   <= '0;
      err     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          elenQ   <= elen;
          laneIdx <= '0;
          err     <= (elen == ELEN_BAD);
          state   <= (elen == ELEN_BAD) ? ST_DONE : ST_AB;
        end
        ST_AB: state <= ST_MU;
        ST_MU: state <= ST_Q;
        ST_Q: begin
          if (laneIdx == lastIdx) begin
            state <= ST_DONE;
          end else begin
            laneIdx <= laneIdx + 1'b1;
            state   <= ST_AB;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_IDLE) && start;
    strobe.mulAB = (state == ST_AB);
    strobe.mulMu = (state == ST_MU);
    strobe.mulQ  = (state == ST_Q);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: an accepted start makes the unit busy on the next cycle
  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> busy);

  // R1: no reload of inputs while an operation runs
  a_r1_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.load);

  // R8: at most one datapath step per cycle
  a_r8_one_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R3: lane index stays inside the lane count of the latched code
  a_r3_lane_bound: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !err) |-> (laneIdx <= lastIdx));

  // R7: an illegal code produces a datapath step never
  a_r7_no_steps_on_err: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !(strobe.mulAB || strobe.mulMu || strobe.mulQ));

endmodule

// File: rtl/mmsimd_dp.sv
module mmsimd_dp
  import mmsimd_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int BASE_W = 32,
  localparam int MAX_W = BASE_W << 2,
  localparam int MAX_LANES = VEC_W / BASE_W,
  localparam int LIDX_W = $clog2(MAX_LANES),
  localparam int SH_W = $clog2(VEC_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mmStrobe_t         strobe,
  input  logic [LIDX_W-1:0] laneIdx,
  input  logic [1:0]        elenQ,
  input  logic [VEC_W-1:0]  vecA,
  input  logic [VEC_W-1:0]  vecB,
  input  logic [MAX_W-1:0]  modQ,
  input  logic [MAX_W-1:0]  muIn,
  output logic [VEC_W-1:0]  result
);

  logic [VEC_W-1:0]   aR, bR;
  logic [MAX_W-1:0]   qR, muR, tR;
  logic [2*MAX_W-1:0] cR;

  logic [SH_W-1:0]    laneW, shAmt;
  logic [MAX_W-1:0]   laneMask, aLane, bLane, mulX, mulY, laneRes;
  logic [2*MAX_W-1:0] prod;
  logic [2*MAX_W:0]   redSum;

  assign laneW    = SH_W'(BASE_W) << elenQ;
  assign shAmt    = SH_W'(laneIdx) * laneW;
  assign laneMask = ~({MAX_W{1'b1}} << laneW);
  assign aLane    = MAX_W'(aR >> shAmt) & laneMask;
  assign bLane    = MAX_W'(bR >> shAmt) & laneMask;

  // one shared multiplier, operands chosen by the active step
  always_comb begin
    mulX = aLane;
    mulY = bLane;
    if (strobe.mulMu) begin
      mulX = cR[MAX_W-1:0] & laneMask;
      mulY = muR & laneMask;
    end else if (strobe.mulQ) begin
      mulX = tR;
      mulY = qR & laneMask;
    end
  end

  assign prod    = {{MAX_W{1'b0}}, mulX} * {{MAX_W{1'b0}}, mulY};
  assign redSum  = {1'b0, cR} + {1'b0, prod};
  assign laneRes = MAX_W'(redSum >> laneW) & laneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aR     <= '0;
      bR     <= '0;
      qR     <= '0;
      muR    <= '0;
      cR     <= '0;
      tR     <= '0;
      result <= '0;
    end else begin
      if (strobe.load) begin
        aR     <= vecA;
        bR     <= vecB;
        qR     <= modQ;
        muR    <= muIn;
        result <= '0;
      end
      if (strobe.mulAB) cR <= prod;
      if (strobe.mulMu) tR <= prod[MAX_W-1:0] & laneMask;
      if (strobe.mulQ)  result <= result | (VEC_W'(laneRes) << shAmt);
    end
  end

  // R6: writing a lane never clears bits of lanes already written
  a_r6_lanes_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mulQ |=> ((result & $past(result)) == $past(result)));

  // R2: result changes only on a load or a lane write
  a_r2_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.mulQ) |=> $stable(result));

  // R4: the reduction factor t never exceeds the lane width
  a_r4_t_in_lane: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mulMu |=> ((tR & ~laneMask) == '0));

endmodule

// File: rtl/mmsimd_montmul.sv
module mmsimd_montmul
  import mmsimd_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int BASE_W = 32,
  localparam int MAX_W = BASE_W << 2,
  localparam int LIDX_W = $clog2(VEC_W / BASE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [1:0]       elenIn,
  input  logic [VEC_W-1:0] vecAIn,
  input  logic [VEC_W-1:0] vecBIn,
  input  logic [MAX_W-1:0] modQIn,
  input  logic [MAX_W-1:0] muIn,
  output logic             busyOut,
  output logic             doneOut,
  output logic             errOut,
  output logic [VEC_W-1:0] resultOut
);

  mmStrobe_t         strobe;
  logic [LIDX_W-1:0] laneIdx;
  logic [1:0]        elenQ;

  mmsimd_ctrl #(.VEC_W(VEC_W), .BASE_W(BASE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(startIn), .elen(elenIn),
    .busy(busyOut), .done(doneOut), .err(errOut),
    .elenQ(elenQ), .laneIdx(laneIdx), .strobe(strobe)
  );

  mmsimd_dp #(.VEC_W(VEC_W), .BASE_W(BASE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .laneIdx(laneIdx),
    .elenQ(elenQ), .vecA(vecAIn), .vecB(vecBIn), .modQ(modQIn),
    .muIn(muIn), .result(resultOut)
  );

  // R7: an illegal code completes with an all-zero result
  a_r7_zero_on_err: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && errOut) |-> (resultOut == '0));

  // R1: done only appears while the unit reports busy
  a_r1_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> busyOut);

endmodule

// File: tb/test_mmsimd_montmul.sv
`timescale 1ns/1ps
module test_mmsimd_montmul;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [1:0]   elenIn = '0;
  logic [255:0] vecAIn = '0, vecBIn = '0;
  logic [127:0] modQIn = '0, muIn = '0;
  logic         busyOut, doneOut, errOut;
  logic [255:0] resultOut;

  always #2 clk = ~clk;

  mmsimd_montmul i_mmsimd_montmul (
    .clk(clk), .rstN(rstN), .startIn(startIn), .elenIn(elenIn),
    .vecAIn(vecAIn), .vecBIn(vecBIn), .modQIn(modQIn), .muIn(muIn),
    .busyOut(busyOut), .doneOut(doneOut), .errOut(errOut),
    .resultOut(resultOut)
  );

  typedef struct {
    logic [255:0] res;
    logic         err;
    int           due;
    string        tag;
  } expItem_t;

  expItem_t sbQ[$];
  int nChecks = 0, nErrs = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, logic [255:0] act, logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [511:0] lmask(int d);
    return (512'd1 << d) - 1;
  endfunction

  // independent lane model of the three-step reduction without final subtraction
  function automatic logic [511:0] laneModel(logic [511:0] a, logic [511:0] b,
                                             logic [511:0] q, logic [511:0] mu, int d);
    logic [511:0] c, t, s;
    c = a * b;
    t = ((c & lmask(d)) * mu) & lmask(d);
    s = c + t * q;
    return (s >> d) & lmask(d);
  endfunction

  function automatic logic [255:0] vecModel(logic [255:0] a, logic [255:0] b,
                                            logic [127:0] q, logic [127:0] mu,
                                            logic [1:0] elen, output bit geQ);
    int d, n;
    logic [511:0] r, acc;
    d = 32 << elen;
    n = 256 / d;
    acc = '0;
    geQ = 0;
    for (int i = 0; i < n; i++) begin
      r = laneModel((512'(a) >> (i*d)) & lmask(d), (512'(b) >> (i*d)) & lmask(d),
                    512'(q) & lmask(d), 512'(mu) & lmask(d), d);
      if (r >= (512'(q) & lmask(d))) geQ = 1;
      acc = acc | (r << (i*d));
    end
    return acc[255:0];
  endfunction

  function automatic logic [127:0] negInv(logic [127:0] q, int d);
    logic [511:0] x, qq;
    qq = 512'(q) & lmask(d);
    x = qq;
    for (int k = 0; k < 7; k++) x = (x * (512'd2 - qq * x)) & lmask(d);
    return 128'(((512'd1 << d) - x) & lmask(d));
  endfunction

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [255:0] rand256();
    return {rand128(), rand128()};
  endfunction

  // driver: pushes the expected item, starts the unit, optionally disturbs it
  task automatic runOp(logic [255:0] a, logic [255:0] b, logic [127:0] q,
                       logic [127:0] mu, logic [1:0] elen, bit disturb, string tag);
    expItem_t it;
    bit geQ;
    int n;
    while (busyOut) @(negedge clk);
    n = (elen == 2'd3) ? 0 : (8 >> elen);
    it.res = (elen == 2'd3) ? '0 : vecModel(a, b, q, mu, elen, geQ);
    it.err = (elen == 2'd3);
    it.due = cyc + 1 + 3 * n;
    it.tag = (elen == 2'd3) ? "R7" : (geQ ? "R4/R5" : "R4/R3");
    if (tag != "") it.tag = tag;
    sbQ.push_back(it);
    vecAIn = a; vecBIn = b; modQIn = q; muIn = mu; elenIn = elen; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    if (disturb) begin
      // R1/R10: new inputs and a second start while busy must be ignored
      vecAIn = rand256(); vecBIn = rand256(); modQIn = rand128(); muIn = rand128();
      elenIn = 2'd3;
      @(negedge clk);
      startIn = 1'b1;
      @(negedge clk);
      startIn = 1'b0;
    end
    while (sbQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares completions with the scoreboard
  initial begin
    expItem_t it;
    bit postChk = 0;
    logic [255:0] heldRes;
    logic heldErr;
    forever begin
      @(negedge clk);
      if (postChk) begin
        check(!doneOut, "R2", "done after one cycle", {255'd0, doneOut}, 256'd0);
        check(resultOut == heldRes && errOut == heldErr, "R2", "result held",
              resultOut, heldRes);
        postChk = 0;
      end
      if (doneOut) begin
        if (sbQ.size() == 0) begin
          check(0, "R2", "unexpected done", 256'd1, 256'd0);
        end else begin
          it = sbQ.pop_front();
          check(resultOut == it.res, it.tag, "result", resultOut, it.res);
          check(errOut == it.err, it.err ? "R7" : "R7", "error flag",
                {255'd0, errOut}, {255'd0, it.err});
          check(cyc == it.due, "R8", "done cycle", 256'(cyc), 256'(it.due));
          heldRes = resultOut;
          heldErr = errOut;
          postChk = 1;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nErrs++;
      nChecks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

  initial begin
    logic [255:0] a, b, v;
    logic [127:0] q, mu;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busyOut && !doneOut && !errOut, "R9", "flags in reset",
          {253'd0, busyOut, doneOut, errOut}, 256'd0);
    check(resultOut == '0, "R9", "result in reset", resultOut, 256'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busyOut && !doneOut, "R9", "idle after reset",
          {254'd0, busyOut, doneOut}, 256'd0);

    // R5: result equal to q is not reduced further
    v = {8{32'h0001_0000}};
    runOp(v, v, 128'd1, 128'hFFFF_FFFF, 2'd0, 0, "R5");

    // R6: only lane 0 non-zero, 128-bit lanes, upper lane stays zero
    q = rand128() | 128'd1 | (128'd1 << 127);
    mu = negInv(q, 128);
    a = {128'd0, rand128() % q};
    b = {128'd0, rand128() % q};
    runOp(a, b, q, mu, 2'd2, 0, "R6");
    // R6: only the top 32-bit lane non-zero
    q = {96'd0, $urandom | 32'h8000_0001};
    mu = negInv(q, 32);
    runOp({$urandom, 224'd0}, {$urandom, 224'd0}, q, mu, 2'd0, 0, "R6");

    // R3/R4: random operands for each legal lane width
    for (int e = 0; e < 3; e++) begin
      for (int k = 0; k < 6; k++) begin
        int d;
        d = 32 << e;
        q = (rand128() & 128'(lmask(d))) | 128'd1;
        mu = negInv(q, d);
        runOp(rand256(), rand256(), q, mu, 2'(e), 0, "");
      end
    end

    // R3: upper bits of q and mu beyond the lane width are ignored
    q = {96'd0, $urandom | 32'd1};
    mu = negInv(q, 32);
    a = rand256(); b = rand256();
    begin
      expItem_t dummy;
      bit g;
      dummy.res = vecModel(a, b, q, mu, 2'd0, g);
      q[127:32] = rand128()[95:0];
      mu[127:32] = rand128()[95:0];
      runOp(a, b, q, mu, 2'd0, 0, "R3");
    end

    // R7: illegal lane-width code
    runOp(rand256(), rand256(), rand128() | 128'd1, rand128(), 2'd3, 0, "R7");

    // R1/R10: start and input changes while busy are ignored
    q = rand128() | 128'd1;
    mu = negInv(q, 64);
    runOp(rand256(), rand256(), q, mu, 2'd1, 1, "R1/R10");
    q = rand128() | 128'd1;
    mu = negInv(q, 128);
    runOp(rand256(), rand256(), q, mu, 2'd2, 1, "R1/R10");

    // R7: error flag clears on the next legal operation
    q = rand128() | 128'd1;
    mu = negInv(q, 32);
    runOp(rand256(), rand256(), q, mu, 2'd0, 0, "R7");

    repeat (4) @(negedge clk);
    check(sbQ.size() == 0, "R2", "all completions seen", 256'(sbQ.size()), 256'd0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule